// File: doc/BRIEF.md
# Device Configuration Header with BAR Size Probing

This block stores the 64-byte configuration header of one device as sixteen 32-bit dwords. A configuration bridge reaches it with single-dword reads and writes, each addressed by a byte offset whose two low bits are ignored. At reset every dword is loaded from a byte-wise parameter image. Byte `4*d + j` of the image becomes bits `8*j+7:8*j` of dword `d`, so the packing is little-endian. The usual fields therefore sit at their normal places: the identifiers in dword 0, the command word in dword 1, class and revision in dword 2, and the interrupt line in the low byte of dword 15.

Dwords 4 through 9 are the six base address register slots, and writes to them are not stored as given. A parameter mask marks which slots are implemented, and each implemented slot has a size given as a power-of-two exponent.

- A write whose value becomes all ones once its two low bits are forced to one is a size probe. After it, the slot reads back the bitwise NOT of (size − 1).
- Any other write to an implemented slot puts back the default value. That default was taken from the image when reset was last asserted.
- Any write to an unimplemented slot leaves it reading zero.

All dwords outside the slot region take the full written value. Offsets at or beyond the header size read as zero, and writes to them change nothing.

Top module: `cfg_header`

## Requirements
- R1: After reset, dword `d` reads the image bytes `4d..4d+3` packed little-endian (byte `4d` in bits 7:0). `rdata` and `rvalid` are zero until the first read.
- R2: A read with `rd_en` high returns data on `rdata` with `rvalid` high one clock later. `rvalid` is low in every cycle that does not follow a read. Offset bits 1:0 are ignored.
- R3: A write to an implemented slot (dwords 4–9, byte offsets 0x10–0x27) with `(wdata | 3) == 32'hFFFF_FFFF` makes it read `~(2**SIZE - 1)`.
- R4: Any other write to an implemented slot makes it read its default, which is the image dword captured at reset. The written value is not kept.
- R5: A write of any value to an unimplemented slot makes it read zero, whatever its image value was.
- R6: A write to any in-range dword outside 4–9 stores all 32 bits. This covers offsets 0x00, 0x0C, 0x28 and the interrupt-line dword at 0x3C. No other dword changes.
- R7: A read at an offset at or beyond the header size (64 bytes) returns zero. A write there changes no dword.
- R8: Asserting reset after writes reloads every dword and every slot default from the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the image |
| wr_en | input | 1 | Write strobe for one dword |
| rd_en | input | 1 | Read strobe for one dword |
| offset | input | 8 | Byte offset into the header (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High in the cycle after a read strobe |

## Verification
A write changes the addressed dword at the edge that samples `wr_en`. A read strobed at the next edge therefore already sees the new value, including the size mask, the restored default or the cleared slot. Read data and `rvalid` appear one edge after `rd_en`. The bench drives every strobe for exactly one cycle from a falling edge and samples `rdata` and `rvalid` at the falling edge that follows the capturing rising edge. One falling edge later it confirms that `rvalid` has dropped. Writes and reads are never strobed in the same cycle, so each expected value depends only on the ordered list of earlier writes and resets.

// File: rtl/cfg_hdr_pkg.sv
// Package cfg_hdr_pkg
// Shared constants, write-action encoding and helper functions for the
// configuration header. Assumes 32-bit dwords and the slot region starting
// at dword 4 as fixed architectural facts.
package cfg_hdr_pkg;

    localparam int CFG_DW       = 32;
    localparam int BAR_BASE_DW  = 4;
    localparam int MAX_BARS     = 6;
    localparam int SZ_W         = 6;

    typedef logic [CFG_DW-1:0] dword_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STORE,
        ACT_PROBE,
        ACT_RESTORE,
        ACT_CLEAR
    } wr_act_e;

    // True when the value, with its two low bits forced high, is all ones.
    function automatic logic is_probe(input dword_t v);
        return ((v | dword_t'(3)) == {CFG_DW{1'b1}});
    endfunction

    // Mask read back after a probe: NOT of (2**lg - 1).
    function automatic dword_t size_mask(input logic [SZ_W-1:0] lg);
        dword_t one_hot;
        one_hot = dword_t'(1) << lg;
        return ~(one_hot - dword_t'(1));
    endfunction

endpackage

// File: rtl/cfg_offset_decode.sv
// Module cfg_offset_decode
// Turns a byte offset into a dword index, an in-range flag, a slot-region
// flag and a slot index. Assumes HDR_BYTES is a power of two and at least 64.
// Purely combinational.
module cfg_offset_decode
    import cfg_hdr_pkg::*;
#(
    parameter int OFS_W     = 8,
    parameter int HDR_BYTES = 64,
    parameter int NUM_BARS  = 6,
    localparam int HDR_DWORDS = HDR_BYTES / 4,
    localparam int IDX_W      = $clog2(HDR_DWORDS)
) (
    input  logic [OFS_W-1:0] offset,
    output logic             in_range,
    output logic [IDX_W-1:0] dw_idx,
    output logic             in_bar_region,
    output logic [2:0]       bar_idx
);

    logic unused_lsb;
    logic [IDX_W-1:0] rel;

    // Offset bits 1:0 carry no meaning for dword accesses.
    assign unused_lsb = ^offset[1:0];

    // Split the offset into range check and dword index.
    always_comb begin
        in_range = (offset < OFS_W'(HDR_BYTES));
        dw_idx   = offset[IDX_W+1:2];
    end

    // Locate the slot region and the slot index inside it.
    always_comb begin
        rel           = dw_idx - IDX_W'(BAR_BASE_DW);
        in_bar_region = in_range
                        && (dw_idx >= IDX_W'(BAR_BASE_DW))
                        && (dw_idx <  IDX_W'(BAR_BASE_DW + NUM_BARS));
        bar_idx       = rel[2:0];
    end

endmodule

// File: rtl/cfg_plain_dword.sv
// Module cfg_plain_dword
// One ordinary header dword: loaded from INIT on reset, takes the full
// written value on a write hit and holds otherwise.
module cfg_plain_dword
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_hit,
    input  dword_t wdata,
    output dword_t value
);

    dword_t q;

    // Hold the dword; reload on reset, replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= INIT;
        else if (wr_hit) q <= wdata;
    end

    assign value = q;

    // R6: a write hit stores the whole value.
    a_r6_full_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (value == $past(wdata)));

    // R6, R7: without a hit the dword keeps its value.
    a_r7_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(value));

endmodule

// File: rtl/cfg_bar_slot.sv
// Module cfg_bar_slot
// One base address register slot. It keeps a default copy captured from the
// image at reset. A probe write makes it read the size mask. Any other write
// restores the default when implemented, or clears the slot when not.
// Assumes SIZE_LOG2 is below 32.
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter bit          IMPL      = 1'b0,
    parameter int          SIZE_LOG2 = 12,
    parameter logic [31:0] DFLT      = 32'h0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_hit,
    input  dword_t wdata,
    output dword_t value
);

    localparam dword_t MASK = size_mask(SZ_W'(SIZE_LOG2));

    dword_t  cur_q;
    dword_t  dflt_q;
    wr_act_e act;

    // Classify the pending write for this slot.
    always_comb begin
        if (!wr_hit)              act = ACT_NONE;
        else if (!IMPL)           act = ACT_CLEAR;
        else if (is_probe(wdata)) act = ACT_PROBE;
        else                      act = ACT_RESTORE;
    end

    // Default copy: captured from the image while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) dflt_q <= DFLT;
    end

    // Current slot value, updated according to the write action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= DFLT;
        end else begin
            case (act)
                ACT_PROBE:   cur_q <= MASK;
                ACT_RESTORE: cur_q <= dflt_q;
                ACT_CLEAR:   cur_q <= '0;
                default:     cur_q <= cur_q;
            endcase
        end
    end

    assign value = cur_q;

    // R3: after a probe, mask plus size wraps to zero.
    a_r3_probe_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && IMPL && ((wdata | 32'h3) == 32'hFFFF_FFFF))
        |=> ((value + (32'h1 << SIZE_LOG2)) == 32'h0));

    // R4: a non-probe write on an implemented slot restores the default.
    a_r4_restore_default: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && IMPL && ((wdata | 32'h3) != 32'hFFFF_FFFF))
        |=> (value == DFLT));

    // R5: an unimplemented slot reads zero after any write.
    a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !IMPL) |=> (value == 32'h0));

    // R7: without a hit the slot keeps its value.
    a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(value));

endmodule

// File: rtl/cfg_header.sv
// Module cfg_header
// Configuration header of a single device. It routes dword writes to plain
// dwords or to slot logic, and it answers reads with one cycle of latency.
// Assumes reads and writes are single-dword strobes. HDR_IMAGE holds byte i
// at bits 8i+7:8i.
module cfg_header
    import cfg_hdr_pkg::*;
#(
    parameter int OFS_W     = 8,
    parameter int HDR_BYTES = 64,
    parameter int NUM_BARS  = 6,
    parameter logic [NUM_BARS-1:0]      BAR_IMPL      = 6'b000011,
    parameter logic [NUM_BARS*SZ_W-1:0] BAR_SIZE_LOG2 =
        {6'd0, 6'd0, 6'd0, 6'd0, 6'd5, 6'd12},
    parameter logic [HDR_BYTES*8-1:0]   HDR_IMAGE =
        512'h0000010B_00000000_00000000_00000000_00000000_00000000_00000000_00000000_DEAD0000_00000000_0000C001_FEB00000_00000000_02000001_00000000_00101B36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] offset,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             rvalid
);

    localparam int HDR_DWORDS = HDR_BYTES / 4;
    localparam int IDX_W      = $clog2(HDR_DWORDS);

    logic             in_range;
    logic [IDX_W-1:0] dw_idx;
    logic             in_bar_region;
    logic [2:0]       bar_idx;
    logic             unused_bar;

    dword_t                dw_val [HDR_DWORDS];
    logic [HDR_DWORDS-1:0] wr_sel;
    dword_t                rd_next;

    cfg_offset_decode #(
        .OFS_W     (OFS_W),
        .HDR_BYTES (HDR_BYTES),
        .NUM_BARS  (NUM_BARS)
    ) u_dec (
        .offset        (offset),
        .in_range      (in_range),
        .dw_idx        (dw_idx),
        .in_bar_region (in_bar_region),
        .bar_idx       (bar_idx)
    );

    // Slot flags are informational at this level; routing uses dw_idx.
    assign unused_bar = in_bar_region ^ (^bar_idx);

    // One-hot write select, empty when the offset is out of range.
    always_comb begin
        wr_sel = '0;
        if (wr_en && in_range) wr_sel[dw_idx] = 1'b1;
    end

    for (genvar d = 0; d < HDR_DWORDS; d++) begin : g_dw
        if (d >= BAR_BASE_DW && d < BAR_BASE_DW + NUM_BARS) begin : g_bar
            cfg_bar_slot #(
                .IMPL      (BAR_IMPL[d-BAR_BASE_DW]),
                .SIZE_LOG2 (int'(BAR_SIZE_LOG2[(d-BAR_BASE_DW)*SZ_W +: SZ_W])),
                .DFLT      (HDR_IMAGE[d*32 +: 32])
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_sel[d]),
                .wdata  (wdata),
                .value  (dw_val[d])
            );
        end else begin : g_plain
            cfg_plain_dword #(
                .INIT (HDR_IMAGE[d*32 +: 32])
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_sel[d]),
                .wdata  (wdata),
                .value  (dw_val[d])
            );
        end
    end

    // Select read data; out-of-range offsets yield zero.
    always_comb begin
        rd_next = in_range ? dw_val[dw_idx] : '0;
    end

    // Register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_next;
        end
    end

    // R2: valid follows a read strobe by exactly one cycle.
    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    a_r2_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R7: out-of-range reads return zero.
    a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (offset >= OFS_W'(HDR_BYTES))) |=> (rdata == 32'h0));

    // R6: at most one dword is targeted by a write.
    a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

endmodule

// File: tb/cfg_header_tb.sv
module cfg_header_tb;

    localparam logic [511:0] IMG =
        512'h0000010B_00000000_00000000_00000000_00000000_00000000_00000000_00000000_DEAD0000_00000000_0000C001_FEB00000_00000000_02000001_00000000_00101B36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  offset = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cfg_header u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .offset (offset),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    // Expected image dword, built byte by byte little-endian.
    function automatic logic [31:0] img_dw(input int d);
        logic [31:0] v;
        for (int j = 0; j < 4; j++) v[8*j +: 8] = IMG[(4*d + j)*8 +: 8];
        return v;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] ofs, input logic [31:0] val);
        @(negedge clk);
        offset = ofs;
        wdata  = val;
        wr_en  = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] ofs, output logic [31:0] val);
        @(negedge clk);
        offset = ofs;
        rd_en  = 1'b1;
        @(negedge clk);
        rd_en  = 1'b0;
        val    = rdata;
        check("R2", "rvalid after read", {31'b0, rvalid}, 32'h1);
    endtask

    task automatic read_check(input string req, input logic [7:0] ofs,
                              input logic [31:0] exp);
        logic [31:0] v;
        do_read(ofs, v);
        check(req, $sformatf("read @%h", ofs), v, exp);
    endtask

    // R1: reset state and image packing.
    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1", "rdata after reset", rdata, 32'h0);
        check("R1", "rvalid after reset", {31'b0, rvalid}, 32'h0);
        for (int d = 0; d < 16; d++) read_check("R1", 8'(4*d), img_dw(d));
    endtask

    // R2: low offset bits ignored, valid drops after the read.
    task automatic t_read_timing();
        read_check("R2", 8'h0B, 32'h0200_0001);
        read_check("R2", 8'h01, 32'h0010_1B36);
        @(negedge clk);
        check("R2", "rvalid idle", {31'b0, rvalid}, 32'h0);
    endtask

    // R3: size probes on implemented slots.
    task automatic t_probe();
        do_write(8'h10, 32'hFFFF_FFFF);
        read_check("R3", 8'h10, 32'hFFFF_F000);
        do_write(8'h14, 32'hFFFF_FFFC);
        read_check("R3", 8'h14, 32'hFFFF_FFE0);
        do_write(8'h10, 32'hFFFF_FFFE);
        read_check("R3", 8'h10, 32'hFFFF_F000);
    endtask

    // R4: non-probe writes restore the captured default.
    task automatic t_restore();
        do_write(8'h10, 32'h1234_5678);
        read_check("R4", 8'h10, 32'hFEB0_0000);
        do_write(8'h14, 32'h7FFF_FFFF);
        read_check("R4", 8'h14, 32'h0000_C001);
        do_write(8'h10, 32'hFFFF_FFFB);
        read_check("R4", 8'h10, 32'hFEB0_0000);
    endtask

    // R5: unimplemented slots clear on write.
    task automatic t_unimpl();
        read_check("R5", 8'h1C, 32'hDEAD_0000);
        do_write(8'h1C, 32'h1111_2222);
        read_check("R5", 8'h1C, 32'h0);
        do_write(8'h24, 32'hFFFF_FFFF);
        read_check("R5", 8'h24, 32'h0);
    endtask

    // R6: plain dwords store the full value; neighbours untouched.
    task automatic t_plain();
        do_write(8'h3C, 32'hA5A5_0155);
        read_check("R6", 8'h3C, 32'hA5A5_0155);
        do_write(8'h00, 32'hCAFE_BEEF);
        read_check("R6", 8'h00, 32'hCAFE_BEEF);
        do_write(8'h0C, 32'h0055_AA00);
        read_check("R6", 8'h0C, 32'h0055_AA00);
        do_write(8'h28, 32'h8765_4321);
        read_check("R6", 8'h28, 32'h8765_4321);
        read_check("R6", 8'h24, 32'h0);
        read_check("R6", 8'h04, 32'h0);
    endtask

    // R7: out-of-range reads give zero, writes change nothing.
    task automatic t_oob();
        read_check("R7", 8'h40, 32'h0);
        read_check("R7", 8'hFC, 32'h0);
        do_write(8'h40, 32'h1357_9BDF);
        do_write(8'h7C, 32'h2468_ACE0);
        read_check("R7", 8'h00, 32'hCAFE_BEEF);
        read_check("R7", 8'h3C, 32'hA5A5_0155);
        read_check("R7", 8'h40, 32'h0);
    endtask

    // R8: reset reloads dwords and slot defaults.
    task automatic t_reload();
        do_write(8'h10, 32'hFFFF_FFFF);
        do_reset();
        read_check("R8", 8'h10, 32'hFEB0_0000);
        read_check("R8", 8'h00, 32'h0010_1B36);
        read_check("R8", 8'h3C, 32'h0000_010B);
        read_check("R8", 8'h1C, 32'hDEAD_0000);
        do_write(8'h14, 32'h0000_0000);
        read_check("R8", 8'h14, 32'h0000_C001);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_read_timing();
        t_probe();
        t_restore();
        t_unimpl();
        t_plain();
        t_oob();
        t_reload();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule